// File: doc/BRIEF.md
# Message Queue Slot

This block is one slot of a message queue that passes whole messages, rather than single words, from a producer to a consumer over a 32-bit register bus. The slot keeps a small FIFO of fixed-size entries. Each entry has a data area, a short header area and a stored word count. A producer reserves the entry at the tail with a claim command and fills its header and data windows word by word. It then commits the message with a ready command that carries the message length. A consumer reads the status register to learn the head message's length, reads the head entry's words through the same windows, and releases the entry with a discard command.

The slot occupies a 16 KiB byte-address space. The command register is at offset 0x0 and the status register at 0x4. The header window starts at 0x1000 and the data window at 0x2000, each word at a successive 4-byte address. A write to a window goes to the claimed tail entry. A read from a window returns the head entry. A purge command empties the slot at any time. Entry count, entry width and header width are all parameters, and the status register reports the first two as log2 values.

Top module: `mq_slot`

## Requirements
- R1: After reset the status register reads full=0 (bit 0) and empty=1 (bit 1), with an occupied count of 0 (bits [15:8]) and a head length of 0 (bits [23:16]).
- R2: Status bits [7:2] always read LOG2_ENTRIES and bits [31:28] always read LOG2_WORDS. Bits [27:24] read 0.
- R3: A command write (offset 0x0) is decoded as follows: bit 24 claims, bit 25 purges, bit 26 commits (ready), bit 27 discards, and bits [7:0] carry the length in words. A ready that follows a claim while the slot is not full appends one message and raises the count by one. The head length then reports the committed length of the oldest message.
- R4: A ready write with no claim outstanding is ignored and leaves the count unchanged. A ready write consumes the claim.
- R5: While the slot is full, claim and ready are both ignored and the count stays at the number of entries.
- R6: Messages leave in commit order. A read at 0x2000+4*i returns word i of the head message, and discard advances to the next message.
- R7: A discard on an empty slot has no effect.
- R8: A purge empties the slot in one cycle and cancels any claim. Later messages are stored and returned correctly from the reset pointer positions.
- R9: A committed length larger than the entry width (2**LOG2_WORDS) is stored and reported as the entry width.
- R10: Read data and its valid flag appear on the cycle after the read request, and the valid flag is low on the cycle after a cycle with no read request.
- R11: The header window at 0x1000+4*i stores per-entry words that are written to the claimed entry and read back from the head entry, following the same ordering as the data window.
- R12: The full flag is set exactly when the count equals 2**LOG2_ENTRIES. Full and empty are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for one bus cycle |
| bus_rd | input | 1 | Read strobe for one bus cycle |
| bus_addr | input | ADDR_W | Byte address within the slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bus_rvalid | output | 1 | High the cycle after a read request |

## Verification
If a pointer or the count goes wrong, the status word shows it on the next status read, one cycle after the request. The count field and the empty and full bits disagree with the number of committed and discarded messages, or the head length no longer matches the oldest committed message. A read pointer that advances wrongly returns another message's words from the data and header windows on the following read. Pointer wrap is covered by offsetting the FIFO position before each fill. Whether a purge also cancels a claim shows up when a ready write that follows the purge appends nothing.

// File: rtl/mq_slot_pkg.sv
package mq_slot_pkg;

  localparam int CMD_CLAIM_BIT   = 24;
  localparam int CMD_PURGE_BIT   = 25;
  localparam int CMD_READY_BIT   = 26;
  localparam int CMD_DISCARD_BIT = 27;
  localparam int CMD_LEN_W       = 8;

  localparam int ST_FULL_BIT     = 0;
  localparam int ST_EMPTY_BIT    = 1;
  localparam int ST_LOGENT_LSB   = 2;
  localparam int ST_COUNT_LSB    = 8;
  localparam int ST_HLEN_LSB     = 16;
  localparam int ST_LOGWID_LSB   = 28;

  typedef struct packed {
    logic                 claim;
    logic                 purge;
    logic                 ready;
    logic                 discard;
    logic [CMD_LEN_W-1:0] len;
  } mq_cmd_t;

  typedef enum logic [1:0] {
    RSEL_ZERO   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_HDR    = 2'd2,
    RSEL_DATA   = 2'd3
  } mq_rsel_e;

endpackage

// File: rtl/mq_cmd_decode.sv
module mq_cmd_decode
  import mq_slot_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int LOG2_WORDS = 3,
  parameter int LOG2_HDR   = 1
) (
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output mq_cmd_t               cmd,
  output logic                  data_we,
  output logic                  hdr_we,
  output logic [LOG2_WORDS-1:0] data_idx,
  output logic [LOG2_HDR-1:0]   hdr_idx,
  output mq_rsel_e              rsel
);

  localparam logic [1:0] WIN_REG  = 2'd0;
  localparam logic [1:0] WIN_HDR  = 2'd1;
  localparam logic [1:0] WIN_DATA = 2'd2;

  logic [1:0] win;
  logic       is_reg, is_hdr, is_dat, cmd_wr;
  logic       unused_bits;

  assign unused_bits = ^{addr, wdata};

  always_comb begin
    win    = addr[ADDR_W-1 -: 2];
    is_reg = (win == WIN_REG);
    is_hdr = (win == WIN_HDR);
    is_dat = (win == WIN_DATA);
    cmd_wr = wr_en && is_reg && !addr[2];

    cmd.claim   = cmd_wr && wdata[CMD_CLAIM_BIT];
    cmd.purge   = cmd_wr && wdata[CMD_PURGE_BIT];
    cmd.ready   = cmd_wr && wdata[CMD_READY_BIT];
    cmd.discard = cmd_wr && wdata[CMD_DISCARD_BIT];
    cmd.len     = wdata[CMD_LEN_W-1:0];

    data_we  = wr_en && is_dat;
    hdr_we   = wr_en && is_hdr;
    data_idx = addr[LOG2_WORDS+1:2];
    hdr_idx  = addr[LOG2_HDR+1:2];

    if (is_reg && addr[2])  rsel = RSEL_STATUS;
    else if (is_hdr)        rsel = RSEL_HDR;
    else if (is_dat)        rsel = RSEL_DATA;
    else                    rsel = RSEL_ZERO;
  end

endmodule

// File: rtl/mq_occupancy.sv
module mq_occupancy
  import mq_slot_pkg::*;
#(
  parameter int LOG2_ENTRIES = 2,
  parameter int LOG2_WORDS   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  mq_cmd_t                 cmd,
  output logic [LOG2_ENTRIES-1:0] wr_ptr,
  output logic [LOG2_ENTRIES-1:0] rd_ptr,
  output logic [LOG2_ENTRIES:0]   count,
  output logic                    claimed,
  output logic                    full,
  output logic                    empty,
  output logic [LOG2_WORDS:0]     head_len
);

  localparam int ENTRIES = 1 << LOG2_ENTRIES;
  localparam int WORDS   = 1 << LOG2_WORDS;
  localparam int PW      = LOG2_ENTRIES;
  localparam int CW      = LOG2_ENTRIES + 1;
  localparam int LW      = LOG2_WORDS + 1;

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          clm_q, clm_d;
  logic          ready_ok, disc_ok, len_we;
  logic [LW-1:0] len_clamped;
  logic [ENTRIES-1:0][LW-1:0] lens;

  assign full  = (cnt_q == CW'(ENTRIES));
  assign empty = (cnt_q == '0);

  always_comb begin
    if ({1'b0, cmd.len} > (CMD_LEN_W+1)'(WORDS)) len_clamped = LW'(WORDS);
    else                                         len_clamped = cmd.len[LW-1:0];

    ready_ok = cmd.ready && clm_q && !full;
    disc_ok  = cmd.discard && !empty;
    len_we   = ready_ok && !cmd.purge;

    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    clm_d = clm_q;
    if (cmd.purge) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      clm_d = 1'b0;
    end else begin
      wr_d  = wr_q + PW'(ready_ok);
      rd_d  = rd_q + PW'(disc_ok);
      cnt_d = cnt_q + CW'(ready_ok) - CW'(disc_ok);
      if (ready_ok)                clm_d = 1'b0;
      else if (cmd.claim && !full) clm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      clm_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      clm_q <= clm_d;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_len
    logic [LW-1:0] len_r;
    logic          hit;
    assign hit = len_we && (wr_q == PW'(e));
    always_ff @(posedge clk) begin
      if (hit) len_r <= len_clamped;
    end
    assign lens[e] = len_r;
  end

  assign head_len = empty ? '0 : lens[rd_q];
  assign wr_ptr   = wr_q;
  assign rd_ptr   = rd_q;
  assign count    = cnt_q;
  assign claimed  = clm_q;

endmodule

// File: rtl/mq_entry_store.sv
module mq_entry_store #(
  parameter int LOG2_ENTRIES = 2,
  parameter int LOG2_WIDTH   = 3
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LOG2_ENTRIES-1:0] wptr,
  input  logic [LOG2_WIDTH-1:0]   widx,
  input  logic [31:0]             wdata,
  input  logic [LOG2_ENTRIES-1:0] rptr,
  input  logic [LOG2_WIDTH-1:0]   ridx,
  output logic [31:0]             rdata
);

  localparam int AW    = LOG2_ENTRIES + LOG2_WIDTH;
  localparam int DEPTH = 1 << AW;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] waddr, raddr;

  assign waddr = {wptr, widx};
  assign raddr = {rptr, ridx};

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mq_slot.sv
module mq_slot
  import mq_slot_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int LOG2_ENTRIES = 2,
  parameter int LOG2_WORDS   = 3,
  parameter int LOG2_HDR     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);

  localparam int PW = LOG2_ENTRIES;
  localparam int CW = LOG2_ENTRIES + 1;
  localparam int LW = LOG2_WORDS + 1;

  logic [1:0]            rst_sync_q;
  logic                  rst_core_n;
  mq_cmd_t               cmd;
  logic                  data_we, hdr_we;
  logic [LOG2_WORDS-1:0] data_idx;
  logic [LOG2_HDR-1:0]   hdr_idx;
  mq_rsel_e              rsel;
  logic [PW-1:0]         wr_ptr, rd_ptr;
  logic [CW-1:0]         count;
  logic                  claimed, full, empty;
  logic [LW-1:0]         head_len;
  logic [31:0]           data_rd, hdr_rd, status, rdata_d, rdata_q;
  logic                  rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  mq_cmd_decode #(
    .ADDR_W(ADDR_W), .LOG2_WORDS(LOG2_WORDS), .LOG2_HDR(LOG2_HDR)
  ) decode_i (
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .cmd(cmd),
    .data_we(data_we), .hdr_we(hdr_we), .data_idx(data_idx),
    .hdr_idx(hdr_idx), .rsel(rsel)
  );

  mq_occupancy #(
    .LOG2_ENTRIES(LOG2_ENTRIES), .LOG2_WORDS(LOG2_WORDS)
  ) occ_i (
    .clk(clk), .rst_n(rst_core_n), .cmd(cmd), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .count(count), .claimed(claimed), .full(full),
    .empty(empty), .head_len(head_len)
  );

  mq_entry_store #(
    .LOG2_ENTRIES(LOG2_ENTRIES), .LOG2_WIDTH(LOG2_WORDS)
  ) data_store_i (
    .clk(clk), .we(data_we && claimed), .wptr(wr_ptr), .widx(data_idx),
    .wdata(bus_wdata), .rptr(rd_ptr), .ridx(data_idx), .rdata(data_rd)
  );

  mq_entry_store #(
    .LOG2_ENTRIES(LOG2_ENTRIES), .LOG2_WIDTH(LOG2_HDR)
  ) hdr_store_i (
    .clk(clk), .we(hdr_we && claimed), .wptr(wr_ptr), .widx(hdr_idx),
    .wdata(bus_wdata), .rptr(rd_ptr), .ridx(hdr_idx), .rdata(hdr_rd)
  );

  always_comb begin
    status                    = '0;
    status[ST_FULL_BIT]       = full;
    status[ST_EMPTY_BIT]      = empty;
    status[ST_LOGENT_LSB +: 6] = 6'(LOG2_ENTRIES);
    status[ST_COUNT_LSB +: 8]  = 8'(count);
    status[ST_HLEN_LSB +: 8]   = 8'(head_len);
    status[ST_LOGWID_LSB +: 4] = 4'(LOG2_WORDS);
  end

  always_comb begin
    case (rsel)
      RSEL_STATUS: rdata_d = status;
      RSEL_HDR:    rdata_d = hdr_rd;
      RSEL_DATA:   rdata_d = data_rd;
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/mq_slot_chk.sv
module mq_slot_chk
  import mq_slot_pkg::*;
#(
  parameter int LOG2_ENTRIES = 2,
  parameter int LOG2_WORDS   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_rd,
  input logic                  bus_rvalid,
  input mq_cmd_t               cmd,
  input logic                  claimed,
  input logic                  full,
  input logic                  empty,
  input logic [LOG2_ENTRIES:0] count,
  input logic [LOG2_WORDS:0]   head_len
);

  localparam int ENTRIES = 1 << LOG2_ENTRIES;
  localparam int WORDS   = 1 << LOG2_WORDS;

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (LOG2_ENTRIES+1)'(ENTRIES));

  assert_purge_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.purge |=> (empty && !claimed));

  assert_ready_noclaim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.ready && !claimed && !cmd.purge && !cmd.discard) |=> $stable(count));

  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cmd.purge && !cmd.discard) |=> full);

  assert_discard_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.discard && empty && !cmd.ready) |=> empty);

  assert_read_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_read_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  assert_head_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    head_len <= (LOG2_WORDS+1)'(WORDS));

endmodule

bind mq_slot mq_slot_chk #(
  .LOG2_ENTRIES(LOG2_ENTRIES), .LOG2_WORDS(LOG2_WORDS)
) chk_i (
  .clk(clk), .rst_n(rst_core_n), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .cmd(cmd), .claimed(claimed), .full(full), .empty(empty),
  .count(count), .head_len(head_len)
);

// File: tb/mq_slot_tb_top.sv
module mq_slot_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 14;
  localparam int LOG2_E = 2;
  localparam int LOG2_W = 3;
  localparam int LOG2_H = 1;
  localparam int ENT    = 1 << LOG2_E;
  localparam int WRD    = 1 << LOG2_W;
  localparam int HWRD   = 1 << LOG2_H;

  localparam logic [31:0] C_CLAIM   = 32'h0100_0000;
  localparam logic [31:0] C_PURGE   = 32'h0200_0000;
  localparam logic [31:0] C_READY   = 32'h0400_0000;
  localparam logic [31:0] C_DISCARD = 32'h0800_0000;

  logic              clk;
  logic              rst_n;
  logic              bus_wr, bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              bus_rvalid;

  int n_chk  = 0;
  int n_fail = 0;
  int msg_no = 0;
  int q_msg[$];
  int q_len[$];
  bit done = 0;

  mq_slot #(.ADDR_W(ADDR_W), .LOG2_ENTRIES(LOG2_E), .LOG2_WORDS(LOG2_W),
            .LOG2_HDR(LOG2_H)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] dpat(int m, int i);
    return {8'(m), 8'hD0, 8'(i), 8'h5A};
  endfunction

  function automatic logic [31:0] hpat(int m, int i);
    return {8'(m), 8'h4E, 8'(i), 8'hC3};
  endfunction

  function automatic int clampw(int l);
    return (l > WRD) ? WRD : l;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d,
                          output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  // Expected status from the model: R2 fields, R12 full, R1/R3 count and head length
  task automatic check_status(input string tag);
    logic [31:0] d, e;
    logic v;
    int cnt, hl;
    cnt = q_len.size();
    hl  = (cnt == 0) ? 0 : q_len[0];
    e = (32'(LOG2_W) << 28) | (32'(hl) << 16) | (32'(cnt) << 8) |
        (32'(LOG2_E) << 2) | ((cnt == 0) ? 32'd2 : 32'd0) |
        ((cnt == ENT) ? 32'd1 : 32'd0);
    bus_read(14'h0004, d, v);
    check({tag, " R10 rvalid"}, {31'd0, v}, 32'd1);
    check(tag, d, e);
  endtask

  task automatic push_msg(input int len);
    msg_no++;
    bus_write(14'h0000, C_CLAIM);
    for (int i = 0; i < WRD; i++) bus_write(ADDR_W'(14'h2000 + 4*i), dpat(msg_no, i));
    for (int i = 0; i < HWRD; i++) bus_write(ADDR_W'(14'h1000 + 4*i), hpat(msg_no, i));
    bus_write(14'h0000, C_READY | 32'(len & 8'hFF));
    q_msg.push_back(msg_no);
    q_len.push_back(clampw(len));
  endtask

  task automatic pop_check(input string tag);
    logic [31:0] d;
    logic v;
    int m, l;
    m = q_msg[0];
    l = q_len[0];
    check_status({tag, " R3 R9 head status"});
    for (int i = 0; i < l; i++) begin
      bus_read(ADDR_W'(14'h2000 + 4*i), d, v);
      check({tag, " R6 data word"}, d, dpat(m, i));
    end
    for (int i = 0; i < HWRD; i++) begin
      bus_read(ADDR_W'(14'h1000 + 4*i), d, v);
      check({tag, " R11 header word"}, d, hpat(m, i));
    end
    bus_write(14'h0000, C_DISCARD);
    void'(q_msg.pop_front());
    void'(q_len.pop_front());
    check_status({tag, " R6 after discard"});
  endtask

  initial begin
    logic [31:0] d;
    logic v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 reset status
    check_status("R1 R2 reset status");
    bus_read(14'h0000, d, v);
    check("R10 command reads zero", d, 32'd0);

    // R4 ready with no claim
    bus_write(14'h0000, C_READY | 32'd3);
    check_status("R4 ready without claim");

    // R7 discard on empty
    bus_write(14'h0000, C_DISCARD);
    check_status("R7 discard on empty");

    for (int r = 0; r < 3; r++) begin
      // shift FIFO position so pointers wrap differently each round
      for (int k = 0; k <= r; k++) begin
        push_msg(2 + k);
        pop_check("R6 offset");
      end
      for (int e = 0; e < ENT; e++) begin
        push_msg((msg_no * 5 + 1) % 13);
        check_status("R3 R12 fill status");
      end
      // R5 claim and ready while full
      bus_write(14'h0000, C_CLAIM);
      bus_write(14'h0000, C_READY | 32'd2);
      check_status("R5 ready while full");
      for (int e = 0; e < ENT; e++) pop_check("R6 R9 drain");
      bus_write(14'h0000, C_DISCARD);
      check_status("R7 discard after drain");
    end

    // R8 purge mid-fill with an outstanding claim
    push_msg(4);
    push_msg(9);
    push_msg(1);
    bus_write(14'h0000, C_CLAIM);
    bus_write(14'h0000, C_PURGE);
    q_msg.delete();
    q_len.delete();
    check_status("R8 purge empties");
    bus_write(14'h0000, C_READY | 32'd5);
    check_status("R8 purge cancels claim");
    push_msg(12);
    push_msg(0);
    check_status("R8 R9 refill after purge");
    pop_check("R8 first after purge");
    pop_check("R8 second after purge");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule